// File: doc/BRIEF.md
# Audio Master-Clock Ratio Detector

This block measures how many system-clock cycles make up one frame of a stereo audio stream. It then decides which of six supported master-clock ratios the stream uses. The frame clock (the left/right word clock) is sampled in the system-clock domain. Every rising edge of that frame clock closes one measurement window.

The measured period is compared with the nominal counts 128, 192, 256, 384, 512 and 768. A small tolerance absorbs edge-sampling uncertainty. No software setting is involved. A ratio code is reported only after the same class has been seen on consecutive frames. An error output flags two cases: a period that fits no supported ratio, and a frame clock that has stopped.

The high ratios (512x and 768x) are refused when the implied frame rate is above a configured limit. The implied frame rate is the system-clock frequency divided by the ratio. With the default 98.304 MHz system clock, 512x would mean 192 kHz frames and is rejected, while 768x means 128 kHz and is accepted.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While and after a synchronous active-high reset, ratio_code is 7, locked is 0 and error is 0, until a measurement or timeout changes them.
- R2: Ratio codes run in ascending ratio order: 0=128x, 1=192x, 2=256x, 3=384x, 4=512x, 5=768x. Code 7 means no valid locked ratio.
- R3: A measured period (system clocks between successive frame-clock rising edges) matches a ratio when it lies within ±2 cycles of the nominal value, inclusive. One cycle outside that window does not match.
- R4: locked rises, and ratio_code shows the class, on the third consecutive measurement with the same class. Each outputs update is visible two clock edges after the edge at which the frame-clock rise is sampled.
- R5: A valid measurement whose class differs from the current one drops locked, sets ratio_code to 7 and restarts the streak count at one.
- R6: A ratio of 512x or more is treated as unsupported when SYSCLK_KHZ divided by the ratio exceeds FS_HIGH_KHZ. With the defaults, 512x is rejected and 768x is accepted.
- R7: A measurement that matches no supported ratio sets error to 1, locked to 0 and ratio_code to 7. The next matching measurement clears error.
- R8: If no frame-clock rise arrives for 1024 system clocks, error is set 1025 edges after the last sampled rise, with locked 0 and ratio_code 7. The next rise serves only as a new reference.
- R9: The first frame-clock rise after reset is a reference only and changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (master) clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame (word) clock, synchronous to clk |
| ratio_code | output | 3 | Detected ratio code, 7 when not locked |
| locked | output | 1 | Classification stable over three frames |
| error | output | 1 | Unsupported period or frame clock absent |

## Verification
Every measurement result is due exactly two clock edges after the edge that samples the frame-clock rise. The driver therefore stamps each expected item with that cycle number, and the monitor compares outputs only on that cycle, at the falling edge.

The timeout is checked at two points after the last rise. At 1000 cycles error must still be low. At 1025 edges it must be high, which pins the 1024-cycle limit from both sides.

Tolerance is probed just inside and just outside the ±2 window. The rejected 512x case and the accepted 768x case are both driven.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef logic [2:0] ratio_code_t;

  localparam ratio_code_t CODE_NONE = 3'd7;
  localparam int NUM_RATIOS = 6;

  // nominal period in system clocks for ratio index i (ascending order)
  function automatic int ratio_nominal(input int idx);
    int base;
    base = (idx % 2 == 0) ? 128 : 192;
    return base << (idx / 2);
  endfunction
endpackage

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int TIMEOUT = 1024,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_clk,
  output logic          meas_valid,
  output logic [CW-1:0] meas_cnt,
  output logic          stall
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          fc_q;
  logic          have_ref;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise  = frame_clk & ~fc_q;
  assign stall = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      fc_q       <= 1'b0;
      have_ref   <= 1'b0;
      cnt        <= '0;
      meas_valid <= 1'b0;
      meas_cnt   <= '0;
    end else begin
      fc_q       <= frame_clk;
      meas_valid <= 1'b0;
      if (rise) begin
        cnt      <= '0;
        have_ref <= 1'b1;
        if (have_ref && !stall) begin
          meas_valid <= 1'b1;
          meas_cnt   <= cnt + 1'b1;
        end
      end else if (!stall) begin
        cnt <= cnt + 1'b1;
      end else begin
        have_ref <= 1'b0;
      end
    end
  end

  // R8: a reported period never exceeds the timeout window
  a_r8_meas_bounded: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> (meas_cnt <= LIMIT));

  // R8: once stalled, the counter holds at the limit until a rise arrives
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (stall && !rise) |=> stall);
endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
  import mrd_pkg::*;
#(
  parameter int CW          = 11,
  parameter int TOL         = 2,
  parameter int SYSCLK_KHZ  = 98304,
  parameter int FS_HIGH_KHZ = 176
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_valid,
  input  logic [CW-1:0] meas_cnt,
  output logic          cls_valid,
  output ratio_code_t   cls_code
);
  logic [NUM_RATIOS-1:0] match;
  ratio_code_t           enc;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
    localparam int  NOM = ratio_nominal(i);
    localparam bit  EN  = !((NOM >= 512) && (SYSCLK_KHZ / NOM > FS_HIGH_KHZ));
    localparam int  LO  = NOM - TOL;
    localparam int  HI  = NOM + TOL;
    if (EN) begin : g_on
      assign match[i] = (int'(meas_cnt) >= LO) && (int'(meas_cnt) <= HI);
    end else begin : g_off
      assign match[i] = 1'b0;
    end
  end

  always_comb begin
    enc = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (match[i]) enc = ratio_code_t'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid <= 1'b0;
      cls_code  <= CODE_NONE;
    end else begin
      cls_valid <= meas_valid;
      if (meas_valid) cls_code <= enc;
    end
  end

  // R3: tolerance windows never overlap, so at most one ratio matches
  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R2: classifier emits only a ratio index or the invalid code
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    cls_valid |-> (cls_code < 3'd6 || cls_code == CODE_NONE));
endmodule

// File: rtl/mrd_lock_tracker.sv
module mrd_lock_tracker
  import mrd_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  localparam int SW = $clog2(LOCK_FRAMES + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cls_valid,
  input  ratio_code_t cls_code,
  input  logic        stall,
  output ratio_code_t ratio_code,
  output logic        locked,
  output logic        error
);
  localparam logic [SW-1:0] LOCK_N = SW'(LOCK_FRAMES);

  ratio_code_t   last_code;
  logic [SW-1:0] streak;
  logic [SW-1:0] streak_nx;

  always_comb begin
    if (cls_code == last_code && streak != '0)
      streak_nx = (streak == LOCK_N) ? streak : streak + 1'b1;
    else
      streak_nx = SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_code  <= CODE_NONE;
      streak     <= '0;
      ratio_code <= CODE_NONE;
      locked     <= 1'b0;
      error      <= 1'b0;
    end else if (stall) begin
      last_code  <= CODE_NONE;
      streak     <= '0;
      ratio_code <= CODE_NONE;
      locked     <= 1'b0;
      error      <= 1'b1;
    end else if (cls_valid) begin
      if (cls_code == CODE_NONE) begin
        last_code  <= CODE_NONE;
        streak     <= '0;
        ratio_code <= CODE_NONE;
        locked     <= 1'b0;
        error      <= 1'b1;
      end else begin
        last_code  <= cls_code;
        streak     <= streak_nx;
        error      <= 1'b0;
        locked     <= (streak_nx == LOCK_N);
        ratio_code <= (streak_nx == LOCK_N) ? cls_code : CODE_NONE;
      end
    end
  end

  // R4: a locked output always carries a real ratio code
  a_r4_locked_has_code: assert property (@(posedge clk) disable iff (rst)
    locked |-> (ratio_code != CODE_NONE));

  // R7: error and lock are mutually exclusive
  a_r7_error_unlocked: assert property (@(posedge clk) disable iff (rst)
    error |-> !locked);

  // R5: a differing class while locked drops the lock
  a_r5_mismatch_drops: assert property (@(posedge clk) disable iff (rst)
    (locked && cls_valid && !stall && cls_code != ratio_code) |=> !locked);

  // R8: a stalled frame clock raises error on the next edge
  a_r8_stall_error: assert property (@(posedge clk) disable iff (rst)
    stall |=> (error && !locked));

  // R4: lock can only appear right after a classification
  a_r4_lock_on_class: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(cls_valid));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int TIMEOUT     = 1024,
  parameter int TOL         = 2,
  parameter int LOCK_FRAMES = 3,
  parameter int SYSCLK_KHZ  = 98304,
  parameter int FS_HIGH_KHZ = 176
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_clk,
  output logic [2:0] ratio_code,
  output logic       locked,
  output logic       error
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          meas_valid;
  logic [CW-1:0] meas_cnt;
  logic          stall;
  logic          cls_valid;
  ratio_code_t   cls_code;

  mrd_period_counter #(.TIMEOUT(TIMEOUT)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .frame_clk  (frame_clk),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt),
    .stall      (stall)
  );

  mrd_classifier #(
    .CW          (CW),
    .TOL         (TOL),
    .SYSCLK_KHZ  (SYSCLK_KHZ),
    .FS_HIGH_KHZ (FS_HIGH_KHZ)
  ) u_classifier (
    .clk        (clk),
    .rst        (rst),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt),
    .cls_valid  (cls_valid),
    .cls_code   (cls_code)
  );

  mrd_lock_tracker #(.LOCK_FRAMES(LOCK_FRAMES)) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .cls_valid  (cls_valid),
    .cls_code   (cls_code),
    .stall      (stall),
    .ratio_code (ratio_code),
    .locked     (locked),
    .error      (error)
  );

  // R1: outputs settle to the idle state in the cycle after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (ratio_code == CODE_NONE && !locked && !error));
endmodule

// File: tb/test_mclk_ratio_detect.sv
module test_mclk_ratio_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_clk = 1'b0;
  logic [2:0] ratio_code;
  logic       locked;
  logic       error;

  always #10 clk = ~clk;

  mclk_ratio_detect i_mclk_ratio_detect (
    .clk        (clk),
    .rst        (rst),
    .frame_clk  (frame_clk),
    .ratio_code (ratio_code),
    .locked     (locked),
    .error      (error)
  );

  typedef struct {
    int         due;
    logic [2:0] code;
    logic       lk;
    logic       er;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // reference model state
  bit         m_have_ref = 0;
  int         m_prev_len = 0;
  logic [2:0] m_last = 3'd7;
  int         m_streak = 0;
  logic [2:0] m_code = 3'd7;
  logic       m_lk = 0;
  logic       m_er = 0;
  int         last_rise_c = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] classify(input int len);
    int nom[6] = '{128, 192, 256, 384, 512, 768};
    bit en[6]  = '{1, 1, 1, 1, 0, 1};  // R6: 512x refused at default clock
    for (int i = 0; i < 6; i++)
      if (en[i] && len >= nom[i] - 2 && len <= nom[i] + 2) return 3'(i);
    return 3'd7;
  endfunction

  task automatic push(input int due);
    exp_t e;
    e.due = due; e.code = m_code; e.lk = m_lk; e.er = m_er; e.tag = cur_tag;
    q.push_back(e);
  endtask

  task automatic drive_frame(input int n);
    int c;
    logic [2:0] k;
    @(negedge clk);
    frame_clk = 1'b1;
    c = cyc;
    last_rise_c = c;
    if (m_have_ref) begin
      k = classify(m_prev_len);
      if (k == 3'd7) begin
        m_er = 1; m_lk = 0; m_code = 3'd7; m_streak = 0; m_last = 3'd7;
      end else begin
        m_er = 0;
        if (k == m_last && m_streak != 0) m_streak = (m_streak < 3) ? m_streak + 1 : 3;
        else m_streak = 1;
        m_last = k;
        m_lk = (m_streak == 3);
        m_code = m_lk ? k : 3'd7;
      end
      push(c + 3);
    end
    m_have_ref = 1;
    m_prev_len = n;
    repeat (n / 2) @(negedge clk);
    frame_clk = 1'b0;
    repeat (n - 1 - n / 2) @(negedge clk);
  endtask

  task automatic go_idle();
    int c;
    c = last_rise_c;
    cur_tag = "R8";
    push(c + 1000);  // still the old state before the limit
    m_er = 1; m_lk = 0; m_code = 3'd7; m_streak = 0; m_last = 3'd7;
    push(c + 1026);
    m_have_ref = 0;
    wait (cyc > c + 1030);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc || ratio_code !== e.code || locked !== e.lk || error !== e.er) begin
        failures++;
        $display("FAIL %s cyc=%0d due=%0d got code=%0d locked=%0b error=%0b exp code=%0d locked=%0b error=%0b",
                 e.tag, cyc, e.due, ratio_code, locked, error, e.code, e.lk, e.er);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (ratio_code !== 3'd7 || locked !== 1'b0 || error !== 1'b0) begin
      failures++;
      $display("FAIL R1 got code=%0d locked=%0b error=%0b exp code=7 locked=0 error=0",
               ratio_code, locked, error);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 after release
    if (ratio_code !== 3'd7 || locked !== 1'b0 || error !== 1'b0) begin
      failures++;
      $display("FAIL R1 got code=%0d locked=%0b error=%0b exp code=7 locked=0 error=0",
               ratio_code, locked, error);
    end

    cur_tag = "R4";   // R9: first rise pushes nothing; R2 code 2
    repeat (5) drive_frame(256);
    cur_tag = "R5";
    repeat (4) drive_frame(384);
    cur_tag = "R3";   // 126/130 within tolerance of 128
    repeat (3) begin drive_frame(126); drive_frame(130); end
    cur_tag = "R6";   // 512x refused
    repeat (3) drive_frame(514);
    cur_tag = "R7";   // 768x accepted, error clears
    repeat (4) drive_frame(768);
    cur_tag = "R2";
    repeat (4) drive_frame(192);
    cur_tag = "R3";   // 259 just outside, 258 just inside
    repeat (2) drive_frame(259);
    repeat (4) drive_frame(258);
    go_idle();
    cur_tag = "R9";   // restart after stall: first rise is reference
    repeat (4) drive_frame(256);
    @(negedge clk);
    frame_clk = 1'b0;
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule